// File: doc/BRIEF.md
# DMA Channel Interrupt and Error Status

This block keeps the per-channel completion and fault status of a multi-channel DMA engine. It holds two bitmaps of one bit per channel. The first records pending transfer-completion interrupt requests. The second records channel error flags. The transfer engine sets bits with single-cycle event pulses. Each pending request bit drives its channel's interrupt line with no gating. An error bit reaches its channel's error interrupt line only when software has enabled that channel in an enable register.

Software clears flags in two ways. It can write a mask to a bitmap, and every 1 in the mask clears that channel. It can also write a channel number to a dedicated clear register, which clears a single flag, or all flags of that type, with no read-modify-write. Software reaches the registers over a simple bus with address, write strobe, write data and a combinational read data port.

Register map (word addresses): 0 request bitmap, 1 error bitmap, 2 error enable, 3 request clear, 4 error clear. Addresses 3 to 7 read as zero. Writes to addresses 5 to 7 do nothing.

Top module: `dma_chan_status`

## Requirements
- R1: After reset the request bitmap, the error bitmap and the error enable register are all zero, and every interrupt output is low.
- R2: A write to address 0 clears each request bit whose write-data bit is 1. Bits written with 0 keep their state.
- R3: A write to address 1 clears each error bit whose write-data bit is 1. Bits written with 0 keep their state.
- R4: A write to address 3 (requests) or address 4 (errors) with bit 6 low clears only the channel numbered by write-data bits [3:0]. Bits 4, 5 and 7 and above are ignored.
- R5: A write to address 3 or 4 with bit 6 high clears every flag of that type, whatever bits [3:0] hold.
- R6: A done pulse on a channel sets its request bit on that clock edge, and the channel's interrupt output follows the request bit with no gating.
- R7: Each error interrupt output is high exactly when that channel's error bit and its enable bit are both 1.
- R8: Reading address 1 returns the raw error flags, whatever the enable register holds.
- R9: When a set pulse and a software clear hit the same bit in the same cycle, the bit ends up set.
- R10: An error pulse on a channel does not stop a done pulse in the same cycle from setting that channel's request bit.
- R11: The error enable register at address 2 reads back what was last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| done_evt | input | NCH | Per-channel transfer-completion pulse |
| err_evt | input | NCH | Per-channel error pulse |
| bus_addr | input | AW | Register word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for bus_addr |
| irq_o | output | NCH | Per-channel completion interrupt |
| err_irq_o | output | NCH | Per-channel enabled error interrupt |

## Verification
The bench builds the block with its defaults: 16 channels and a 16-bit data bus. This makes the channel field in the clear registers exactly four bits wide. Channel 15, the top of that field, and the ignored bits just above it can then be tested directly. It also lets a bitmap write cover every channel at once, so the collisions of a mask clear with a done pulse or an error pulse on the same bit can be reached.

// File: rtl/dma_chan_status.sv
module dma_chan_status #(
  parameter int NCH = 16,
  parameter int AW  = 3,
  parameter int DW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] done_evt,
  input  logic [NCH-1:0] err_evt,
  input  logic [AW-1:0]  bus_addr,
  input  logic           bus_we,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  output logic [NCH-1:0] irq_o,
  output logic [NCH-1:0] err_irq_o
);
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int ALL_BIT = 6;
  localparam logic [AW-1:0] A_IRQ  = AW'(0);
  localparam logic [AW-1:0] A_ERR  = AW'(1);
  localparam logic [AW-1:0] A_EN   = AW'(2);
  localparam logic [AW-1:0] A_CLRI = AW'(3);
  localparam logic [AW-1:0] A_CLRE = AW'(4);

  logic [NCH-1:0] irq_q, err_q, en_q, pick, irq_clr, err_clr;

  for (genvar i = 0; i < NCH; i++) begin : g_pick
    assign pick[i] = bus_wdata[ALL_BIT] || (bus_wdata[CW-1:0] == CW'(i));
  end

  always_comb begin
    irq_clr = '0;
    err_clr = '0;
    if (bus_we) begin
      case (bus_addr)
        A_IRQ:   irq_clr = bus_wdata[NCH-1:0];
        A_ERR:   err_clr = bus_wdata[NCH-1:0];
        A_CLRI:  irq_clr = pick;
        A_CLRE:  err_clr = pick;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= '0;
      err_q <= '0;
      en_q  <= '0;
    end else begin
      irq_q <= (irq_q & ~irq_clr) | done_evt;
      err_q <= (err_q & ~err_clr) | err_evt;
      if (bus_we && bus_addr == A_EN) en_q <= bus_wdata[NCH-1:0];
    end
  end

  assign irq_o     = irq_q;
  assign err_irq_o = err_q & en_q;

  always_comb begin
    case (bus_addr)
      A_IRQ:   bus_rdata = DW'(irq_q);
      A_ERR:   bus_rdata = DW'(err_q);
      A_EN:    bus_rdata = DW'(en_q);
      default: bus_rdata = '0;
    endcase
  end

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt != '0) |=> ((irq_o & $past(done_evt)) == $past(done_evt)));
  assert_err_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_evt != '0) |=> ((bus_addr != A_ERR) || ((bus_rdata[NCH-1:0] & $past(err_evt)) == $past(err_evt))));
  assert_w1c_irq_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_IRQ) |=> ((irq_o & $past(bus_wdata[NCH-1:0] & ~done_evt)) == '0));
  assert_hold_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && (bus_addr == A_ERR || bus_addr == A_CLRE)) |=> ((err_q & $past(err_q)) == $past(err_q)));
  assert_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> (err_irq_o == '0));
endmodule

// File: tb/dma_chan_status_bench.sv
`timescale 1ns/1ps
module dma_chan_status_bench;
  logic clk = 0, rst_n = 0;
  logic [15:0] done_evt = 0, err_evt = 0, bus_wdata = 0, bus_rdata, irq_o, err_irq_o;
  logic [2:0] bus_addr = 0;
  logic bus_we = 0;
  int checks = 0, errors = 0;
  logic [15:0] mi = 0, me = 0, men = 0;

  always #2.5 clk = ~clk;

  dma_chan_status u_dma_chan_status (.clk, .rst_n, .done_evt, .err_evt, .bus_addr,
    .bus_we, .bus_wdata, .bus_rdata, .irq_o, .err_irq_o);

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mread(input logic [2:0] a);
    case (a)
      3'd0: return mi;
      3'd1: return me;
      3'd2: return men;
      default: return 16'h0;
    endcase
  endfunction

  task automatic step(input logic [15:0] d, input logic [15:0] e, input logic we,
                      input logic [2:0] a, input logic [15:0] wd);
    @(negedge clk);
    done_evt = d; err_evt = e; bus_we = we; bus_addr = a; bus_wdata = wd;
    @(posedge clk);
    for (int i = 0; i < 16; i++) begin
      bit hit = (wd[6] || wd[3:0] == i);
      if (we && ((a == 0 && wd[i]) || (a == 3 && hit))) mi[i] = 0;
      if (we && ((a == 1 && wd[i]) || (a == 4 && hit))) me[i] = 0;
      if (d[i]) mi[i] = 1;
      if (e[i]) me[i] = 1;
    end
    if (we && a == 2) men = wd;
    #1;
    chk("R6 irq_o", irq_o, mi);
    chk("R7 err_irq_o", err_irq_o, me & men);
    chk("R8 bus_rdata", bus_rdata, mread(a));
  endtask

  task automatic rd(input logic [2:0] a, input string tag, input logic [15:0] exp);
    step(0, 0, 0, a, 0);
    chk(tag, bus_rdata, exp);
  endtask

  initial begin
    #20000000;
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #12 rst_n = 1;
    #1;
    chk("R1 irq_o", irq_o, 0);
    chk("R1 err_irq_o", err_irq_o, 0);
    rd(0, "R1 req", 16'h0); rd(1, "R1 err", 16'h0); rd(2, "R1 en", 16'h0);
    step(16'h8001, 0, 0, 0, 0);
    chk("R6 set", irq_o, 16'h8001);
    step(0, 0, 1, 0, 16'h0001);
    rd(0, "R2 w1c", 16'h8000);
    step(16'h0010, 16'h00F0, 0, 0, 0);
    chk("R10 done with err", irq_o, 16'h8010);
    rd(1, "R8 raw", 16'h00F0);
    chk("R7 masked", err_irq_o, 16'h0);
    step(0, 0, 1, 2, 16'h0030);
    rd(2, "R11 en", 16'h0030);
    chk("R7 enabled", err_irq_o, 16'h0030);
    step(0, 0, 1, 1, 16'h0010);
    rd(1, "R3 w1c", 16'h00E0);
    step(0, 0, 1, 4, 16'h00A5);
    rd(1, "R4 clre ch5", 16'h00C0);
    step(0, 0, 1, 3, 16'h000F);
    rd(0, "R4 clri ch15", 16'h0010);
    step(16'h0004, 0, 1, 3, 16'h0002);
    rd(0, "R9 set wins clri", 16'h0014);
    step(16'h0004, 0, 1, 0, 16'h0004);
    rd(0, "R9 set wins w1c", 16'h0014);
    step(0, 16'h0100, 1, 4, 16'h0008);
    rd(1, "R9 err set wins", 16'h01C0);
    step(0, 0, 1, 3, 16'h0043);
    rd(0, "R5 clear all req", 16'h0);
    step(0, 0, 1, 4, 16'h004F);
    rd(1, "R5 clear all err", 16'h0);
    step(0, 0, 1, 6, 16'hFFFF);
    rd(6, "R4 other addr", 16'h0);
    rd(3, "R4 clr reads 0", 16'h0);
    for (int n = 0; n < 400; n++)
      step(16'($urandom) & 16'($urandom), 16'($urandom) & 16'($urandom),
           1'($urandom), 3'($urandom), 16'($urandom));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule